// File: doc/BRIEF.md
# Disciplined PTP Hardware Clock

This block keeps a 64-bit free-running time counter in units of 8 ns ticks that a host can steer over a small synchronous register bus. A 32-bit rate word, centred on 2^31, trims how fast the counter advances. The host can also step the time: one 64-bit clock-value port either replaces the counter or adds a signed offset to it, depending on a mode bit held in the command word. The same command word carries a self-clearing bit that zeroes the counter.

Rate control uses a 32-bit phase accumulator. On every enabled cycle the rate word is added to the accumulator. A carry out advances the counter by two ticks, and no carry advances it by one. A fixed divider enables two cycles out of every three. At the midpoint rate this gives exactly one tick per cycle, so a 125 MHz clock keeps nominal time. The host reads the counter as two 32-bit words. Reading the low word freezes the high word, so the pair stays coherent across a carry between the words.

Bus timing: inputs are sampled on the rising clock edge. Register writes take effect at the edge that samples them. Read data appears on the bus one cycle after the read strobe and holds until the next read.

Top module: `phc_time_core`

## Requirements
- R1: After reset, the counter is 0, the rate word reads 0x8000_0000, and the command word reads 0.
- R2: The enable divider runs with period 3 and is enabled in phases 0 and 1 of each period. On an enabled cycle the accumulator gains the rate word, and the counter grows by 2 on a carry out of bit 31 and by 1 otherwise. On the disabled phase the counter does not change. At rate 0x8000_0000 the counter gains exactly 6 ticks in every 6 cycles after a clear.
- R3: A write to word address 1 sets the rate word. The new value is used from the next cycle onward and reads back at address 1.
- R4: A write to address 2 stages the low 32 bits of a clock value. A write to address 3 supplies the high 32 bits and commits the value. In set mode (mode bit 0), the counter equals the committed value after that edge.
- R5: In add mode (mode bit 1), a commit makes the counter equal to the old count, plus that cycle's tick step, plus the 64-bit two's-complement value. The tick step is not lost when the two coincide.
- R6: The command word is at address 0. Bit 31 must be 1 for a write to take effect, bit 2 requests a clear, and bit 0 is the mode. A write with bit 31 at 0 changes nothing.
- R7: A clear request zeroes the counter, the accumulator and the divider at the edge after the write. Bit 2 reads 1 for that one cycle only.
- R8: Reading address 2 returns the counter's low word at the sampling edge and captures its high word. Reading address 3 returns the captured high word. Read data appears one cycle after the strobe.
- R9: The mode bit keeps its value across commits and clears until the next valid command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, nominally 8 ns period |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | 2 | Word address: 0 command, 1 rate, 2 time low, 3 time high |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, one cycle after the read strobe |
| timeNow | output | 64 | Current time in ticks |

## Verification
An add-mode commit can land on the same cycle as an accumulator carry, so the counter must take both the offset and the two-tick step at one edge. The bench drives a train of negative-offset commits with a different idle gap after each one. This places the commits on every divider phase, including carry phases and the disabled phase. A cycle-by-cycle predictor built from the tick rule then judges the counter on every cycle. A clear request also has to override a commit issued on the following cycle. Low-word reads taken across a 32-bit rollover confirm that the captured high word pairs with the low word sampled at the same edge.

// File: rtl/phc_pkg.sv
package phc_pkg;

  localparam int unsigned TIME_W   = 64;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned RATE_W   = 32;
  localparam int unsigned ADDR_W   = 2;

  localparam int unsigned CMD_VALID_BIT = 31;
  localparam int unsigned CMD_CLEAR_BIT = 2;
  localparam int unsigned CMD_MODE_BIT  = 0;

  localparam logic [RATE_W-1:0] RATE_NOMINAL = {1'b1, {(RATE_W-1){1'b0}}};

  typedef enum logic [ADDR_W-1:0] {
    REG_CMD  = 2'd0,
    REG_RATE = 2'd1,
    REG_TLO  = 2'd2,
    REG_THI  = 2'd3
  } regSel_e;

  typedef struct packed {
    logic              clear;
    logic              load;
    logic              add;
    logic              snap;
    logic [TIME_W-1:0] value;
  } dpCtl_t;

endpackage

// File: rtl/phc_ctrl.sv
module phc_ctrl
  import phc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wrData,
  input  logic [WORD_W-1:0] timeLo,
  input  logic [WORD_W-1:0] hiLatch,
  output logic [RATE_W-1:0] rate,
  output dpCtl_t            ctl,
  output logic [WORD_W-1:0] rdData
);

  logic              modeQ;
  logic              clearPendQ;
  logic [RATE_W-1:0] rateQ;
  logic [WORD_W-1:0] stageQ;
  logic [WORD_W-1:0] rdDataQ;

  logic              cmdWr;
  logic              commitWr;
  logic [WORD_W-1:0] cmdWord;
  logic [WORD_W-1:0] rdMux;

  assign cmdWr    = wrEn && (addr == REG_CMD) && wrData[CMD_VALID_BIT];
  assign commitWr = wrEn && (addr == REG_THI);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ      <= 1'b0;
      clearPendQ <= 1'b0;
      rateQ      <= RATE_NOMINAL;
      stageQ     <= '0;
      rdDataQ    <= '0;
    end else begin
      clearPendQ <= cmdWr && wrData[CMD_CLEAR_BIT];
      if (cmdWr) modeQ <= wrData[CMD_MODE_BIT];
      if (wrEn && (addr == REG_RATE)) rateQ <= wrData[RATE_W-1:0];
      if (wrEn && (addr == REG_TLO)) stageQ <= wrData;
      if (rdEn) rdDataQ <= rdMux;
    end
  end

  always_comb begin
    cmdWord = '0;
    cmdWord[CMD_MODE_BIT]  = modeQ;
    cmdWord[CMD_CLEAR_BIT] = clearPendQ;
  end

  always_comb begin
    unique case (addr)
      REG_CMD:  rdMux = cmdWord;
      REG_RATE: rdMux = WORD_W'(rateQ);
      REG_TLO:  rdMux = timeLo;
      default:  rdMux = hiLatch;
    endcase
  end

  always_comb begin
    ctl.clear = clearPendQ;
    ctl.load  = commitWr && !modeQ;
    ctl.add   = commitWr && modeQ;
    ctl.snap  = rdEn && (addr == REG_TLO);
    ctl.value = {wrData, stageQ};
  end

  assign rate   = rateQ;
  assign rdData = rdDataQ;

endmodule

// File: rtl/phc_datapath.sv
module phc_datapath
  import phc_pkg::*;
#(
  parameter int unsigned DivPeriod = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [RATE_W-1:0] rate,
  input  dpCtl_t            ctl,
  output logic [TIME_W-1:0] timeNow,
  output logic [WORD_W-1:0] hiLatch
);

  logic              tickEn;
  logic [RATE_W-1:0] accQ;
  logic [RATE_W:0]   phaseSum;
  logic [TIME_W-1:0] step;
  logic [TIME_W-1:0] timeQ;
  logic [WORD_W-1:0] hiQ;

  generate
    if (DivPeriod > 1) begin : g_div
      localparam int unsigned DivW = $clog2(DivPeriod);
      localparam logic [DivW-1:0] DivLast = DivW'(DivPeriod - 1);
      logic [DivW-1:0] divQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                divQ <= '0;
        else if (ctl.clear)       divQ <= '0;
        else if (divQ == DivLast) divQ <= '0;
        else                      divQ <= divQ + 1'b1;
      end
      assign tickEn = (divQ != DivLast);
    end else begin : g_nodiv
      assign tickEn = 1'b1;
    end
  endgenerate

  assign phaseSum = {1'b0, accQ} + {1'b0, rate};

  always_comb begin
    if (!tickEn)                step = '0;
    else if (phaseSum[RATE_W])  step = TIME_W'(2);
    else                        step = TIME_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ  <= '0;
      timeQ <= '0;
    end else if (ctl.clear) begin
      accQ  <= '0;
      timeQ <= '0;
    end else begin
      if (tickEn) accQ <= phaseSum[RATE_W-1:0];
      if (ctl.load)     timeQ <= ctl.value;
      else if (ctl.add) timeQ <= timeQ + step + ctl.value;
      else              timeQ <= timeQ + step;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         hiQ <= '0;
    else if (ctl.snap) hiQ <= timeQ[TIME_W-1:WORD_W];
  end

  assign timeNow = timeQ;
  assign hiLatch = hiQ;

endmodule

// File: rtl/phc_time_core.sv
module phc_time_core
  import phc_pkg::*;
#(
  parameter int unsigned DivPeriod = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWrData,
  output logic [WORD_W-1:0] busRdData,
  output logic [TIME_W-1:0] timeNow
);

  dpCtl_t            dpCtl;
  logic [RATE_W-1:0] rate;
  logic [WORD_W-1:0] hiLatch;

  phc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (busWrEn),
    .rdEn    (busRdEn),
    .addr    (busAddr),
    .wrData  (busWrData),
    .timeLo  (timeNow[WORD_W-1:0]),
    .hiLatch (hiLatch),
    .rate    (rate),
    .ctl     (dpCtl),
    .rdData  (busRdData)
  );

  phc_datapath #(.DivPeriod(DivPeriod)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .rate    (rate),
    .ctl     (dpCtl),
    .timeNow (timeNow),
    .hiLatch (hiLatch)
  );

endmodule

// File: rtl/phc_time_core_chk.sv
module phc_time_core_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busWrEn,
  input logic        busRdEn,
  input logic [1:0]  busAddr,
  input logic [31:0] busWrData,
  input logic [31:0] busRdData,
  input logic [63:0] timeNow
);

  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (timeNow == 64'd0)); // R1

  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrEn && !$past(busWrEn)) |=> ((timeNow - $past(timeNow)) <= 64'd2)); // R2

  AST_RATE_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd1) ##1 (busRdEn && busAddr == 2'd1)
      |=> (busRdData == $past(busWrData, 2))); // R3

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd0 && busWrData[31] && busWrData[2])
      |=> ##1 (timeNow == 64'd0)); // R7

  AST_LOW_SNAPSHOT: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr == 2'd2) |=> (busRdData == $past(timeNow[31:0]))); // R8

endmodule

bind phc_time_core phc_time_core_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busRdEn   (busRdEn),
  .busAddr   (busAddr),
  .busWrData (busWrData),
  .busRdData (busRdData),
  .timeNow   (timeNow)
);

// File: tb/phc_time_core_bench.sv
module phc_time_core_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic        busRdEn = 1'b0;
  logic [1:0]  busAddr = 2'd0;
  logic [31:0] busWrData = 32'd0;
  logic [31:0] busRdData;
  logic [63:0] timeNow;

  always #10 clk = ~clk;

  phc_time_core u_phc_time_core (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .timeNow   (timeNow)
  );

  int    nCmp = 0;
  int    nBad = 0;
  bit    done = 1'b0;
  string curTag = "R1";

  logic [31:0] expQ[$];
  string       tagQ[$];

  logic [63:0] mT = 64'd0;
  logic [31:0] mAcc = 32'd0;
  logic [31:0] mRate = 32'h8000_0000;
  logic [31:0] mStage = 32'd0;
  logic [31:0] mHi = 32'd0;
  int          mDiv = 0;
  logic        mMode = 1'b0;
  logic        mPend = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    nCmp++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Predictor: applies the requirement rules at each edge and queues read results
  always @(posedge clk) begin : predictor
    logic [32:0] s;
    logic [63:0] inc;
    logic        en;
    if (!rstN) begin
      mT = 64'd0; mAcc = 32'd0; mRate = 32'h8000_0000; mStage = 32'd0;
      mHi = 32'd0; mDiv = 0; mMode = 1'b0; mPend = 1'b0;
    end else begin
      if (busRdEn) begin
        tagQ.push_back(curTag);
        if (busAddr == 2'd0)      expQ.push_back({29'd0, mPend, 1'b0, mMode});
        else if (busAddr == 2'd1) expQ.push_back(mRate);
        else if (busAddr == 2'd2) begin
          expQ.push_back(mT[31:0]);
          mHi = mT[63:32];
        end else                  expQ.push_back(mHi);
      end
      en  = (mDiv != 2);
      s   = {1'b0, mAcc} + {1'b0, mRate};
      inc = en ? (s[32] ? 64'd2 : 64'd1) : 64'd0;
      if (mPend) begin
        mT = 64'd0; mAcc = 32'd0; mDiv = 0;
      end else begin
        mDiv = (mDiv == 2) ? 0 : mDiv + 1;
        if (en) mAcc = s[31:0];
        if (busWrEn && busAddr == 2'd3)
          mT = mMode ? (mT + inc + {busWrData, mStage}) : {busWrData, mStage};
        else
          mT = mT + inc;
      end
      mPend = busWrEn && busAddr == 2'd0 && busWrData[31] && busWrData[2];
      if (busWrEn && busAddr == 2'd0 && busWrData[31]) mMode = busWrData[0];
      if (busWrEn && busAddr == 2'd1) mRate = busWrData;
      if (busWrEn && busAddr == 2'd2) mStage = busWrData;
    end
  end

  // Monitor: compares the time output every cycle and pops read results
  always @(negedge clk) begin
    if (rstN && !done) begin
      check(timeNow == mT, curTag, "timeNow", timeNow, mT);
      if (expQ.size() > 0) begin
        logic [31:0] e;
        string       t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(busRdData == e, t, "busRdData", {32'd0, busRdData}, {32'd0, e});
      end
    end
  end

  // Driver tasks: called at a falling edge, return at the next falling edge
  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a);
    busRdEn = 1'b1; busAddr = a;
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(timeNow == 64'd0, "R1", "timeNow in reset", timeNow, 64'd0);
    rstN = 1'b1;
    curTag = "R1";
    @(negedge clk);
    rd(2'd0);
    rd(2'd1);
    curTag = "R2";
    idle(30);
    curTag = "R3";
    wr(2'd1, 32'h0000_0000);
    rd(2'd1);
    idle(12);
    wr(2'd1, 32'hFFFF_FFFF);
    idle(12);
    wr(2'd1, 32'h8400_0000);
    rd(2'd1);
    idle(9);
    wr(2'd1, 32'h8000_0000);
    curTag = "R4";
    wr(2'd2, 32'hFFFF_FFF0);
    wr(2'd3, 32'h0000_0001);
    idle(1);
    curTag = "R8";
    for (int i = 0; i < 8; i++) begin
      rd(2'd2);
      rd(2'd3);
      idle(1);
    end
    curTag = "R6";
    wr(2'd0, 32'h8000_0001);
    rd(2'd0);
    curTag = "R5";
    for (int i = 0; i < 6; i++) begin
      wr(2'd2, 32'hFFFF_FF9C);
      wr(2'd3, 32'hFFFF_FFFF);
      idle(i);
    end
    wr(2'd2, 32'h0000_0010);
    wr(2'd3, 32'h0000_0000);
    idle(2);
    curTag = "R6";
    wr(2'd0, 32'h0000_0004);
    rd(2'd0);
    wr(2'd0, 32'h0000_0000);
    rd(2'd0);
    idle(4);
    curTag = "R7";
    wr(2'd0, 32'h8000_0005);
    rd(2'd0);
    rd(2'd0);
    wr(2'd2, 32'h1234_5678);
    wr(2'd0, 32'h8000_0005);
    wr(2'd3, 32'h0000_0009);
    idle(7);
    curTag = "R9";
    wr(2'd2, 32'h0000_0100);
    wr(2'd3, 32'h0000_0000);
    rd(2'd0);
    wr(2'd0, 32'h8000_0000);
    rd(2'd0);
    wr(2'd2, 32'hCAFE_0000);
    wr(2'd3, 32'h0000_0002);
    rd(2'd2);
    rd(2'd3);
    idle(6);
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nCmp++;
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

endmodule